// File: doc/BRIEF.md
# Cache Line Maintenance Sequencer

This block carries out the three software-issued maintenance operations on a single data-cache line: clean (write a dirty line back and keep it), flush (write a dirty line back and drop it) and invalidate (drop the line, discarding any dirty data). Each request arrives with its address, the outcome of the tag lookup, the line's current coherence state and the results of the translation-side permission checks. The block then produces one of four results: a state update for the state array, a writeback request to the memory port, a broadcast of the operation to the system bus, or a fault report.

A dirty line is written back before its state changes. The block holds `busy` from the moment it accepts such a request until the memory port acknowledges. The state array is updated only after that handshake completes. Every address the block emits is aligned down to the line boundary.

Top module: `cache_maint_ctrl`

## Requirements
- R1: Encodings are as follows. `cmd_op` is 01 for clean, 10 for flush, 11 for invalidate and 00 for no operation. Line states are I=00, S=01, E=10 and M=11. A request is accepted on a rising edge where `cmd_valid` is high, `busy` is low and `cmd_op` is not 00. Its immediate results (`upd_*`, `exc_*`, `bcast_*`, `wb_req`) appear after that edge and pulse for one cycle. `wb_req` is the exception: it stays high until acknowledged.
- R2: A clean that hits an M line raises `wb_req`. After the edge where `wb_ack` is sampled high, the block pulses `upd_valid` with `upd_state` = E.
- R3: A clean that hits an E or S line produces no writeback and no state update.
- R4: A flush that hits an M line raises `wb_req`. After the acknowledge, the block pulses `upd_valid` with `upd_state` = I.
- R5: A flush that hits an E or S line pulses `upd_valid` with `upd_state` = I right away, with no writeback.
- R6: An invalidate that hits a valid line pulses `upd_valid` with `upd_state` = I right away. It never writes back, even for an M line.
- R7: Any request that misses, or that hits a line already in state I, produces no update and no writeback. A request with `cmd_op` = 00 produces no output at all.
- R8: An invalidate issued with `user_mode` high is rejected with `exc_valid` and `exc_cause` = 10, whether it hits or misses. This privilege fault takes precedence over a permission fault.
- R9: Clean and flush are checked against `prot_load_ok`, and invalidate against `prot_store_ok`. A failed check raises `exc_valid` with `exc_cause` = 01. A faulted request causes no update, no writeback and no broadcast.
- R10: Every accepted, non-faulted request pulses `bcast_valid` with `bcast_op` and a line-aligned `bcast_addr` if `bcast_enable` is high, whether it hits or misses. It produces no broadcast otherwise.
- R11: `cache_disabled`, `cache_locked` and `cmd_attr` have no effect on any output.
- R12: `busy` stays high from the acceptance of a writeback until the acknowledge edge. `wb_req` holds until `wb_ack` is sampled. Requests presented while `busy` is high are ignored.
- R13: While `rst_n` is low, every output is low and any writeback in progress is abandoned.
- R14: `wb_addr`, `upd_addr`, `bcast_addr` and `exc_addr` carry the request address with its low log2(LINE_BYTES) bits cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Request present |
| cmd_op | input | 2 | Operation code |
| cmd_addr | input | ADDR_W | Request address |
| cmd_hit | input | 1 | Tag lookup hit |
| cmd_state | input | 2 | Current line state |
| cmd_attr | input | 4 | Line memory attributes (ignored) |
| cache_disabled | input | 1 | Cache disabled (ignored) |
| cache_locked | input | 1 | Cache locked (ignored) |
| prot_load_ok | input | 1 | Read permission check passed |
| prot_store_ok | input | 1 | Write permission check passed |
| user_mode | input | 1 | Requester in user mode |
| bcast_enable | input | 1 | Global broadcast enable |
| busy | output | 1 | Writeback in progress; requests ignored |
| wb_req | output | 1 | Writeback request to memory port |
| wb_addr | output | ADDR_W | Writeback line address |
| wb_ack | input | 1 | Writeback acknowledge |
| upd_valid | output | 1 | State-array update pulse |
| upd_state | output | 2 | New line state |
| upd_addr | output | ADDR_W | Line address of update |
| bcast_valid | output | 1 | Bus broadcast pulse |
| bcast_op | output | 2 | Broadcast operation code |
| bcast_addr | output | ADDR_W | Broadcast line address |
| exc_valid | output | 1 | Data-storage fault pulse |
| exc_cause | output | 2 | 01 permission, 10 privilege |
| exc_addr | output | ADDR_W | Faulting line address |

## Verification
The hardest case to reach is a second request arriving while a writeback is still waiting for its acknowledge. The bench steers into it by issuing a dirty clean or flush and holding `wb_ack` low for several cycles. During that window it offers an invalidate that would otherwise update the line and broadcast. After the acknowledge, the bench confirms that only the deferred update appears and that nothing from the ignored request leaks out later. A reset asserted in the middle of a writeback is also driven, to show that the pending request is dropped.

// File: rtl/cache_maint_ctrl.sv
module cache_maint_ctrl #(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic              cmd_hit,
  input  logic [1:0]        cmd_state,
  input  logic [3:0]        cmd_attr,
  input  logic              cache_disabled,
  input  logic              cache_locked,
  input  logic              prot_load_ok,
  input  logic              prot_store_ok,
  input  logic              user_mode,
  input  logic              bcast_enable,
  output logic              busy,
  output logic              wb_req,
  output logic [ADDR_W-1:0] wb_addr,
  input  logic              wb_ack,
  output logic              upd_valid,
  output logic [1:0]        upd_state,
  output logic [ADDR_W-1:0] upd_addr,
  output logic              bcast_valid,
  output logic [1:0]        bcast_op,
  output logic [ADDR_W-1:0] bcast_addr,
  output logic              exc_valid,
  output logic [1:0]        exc_cause,
  output logic [ADDR_W-1:0] exc_addr
);
  localparam int OFF_W = $clog2(LINE_BYTES);
  localparam logic [1:0] ST_I = 2'b00, ST_S = 2'b01, ST_E = 2'b10, ST_M = 2'b11;
  localparam logic [1:0] OP_NONE = 2'b00, OP_CLEAN = 2'b01, OP_FLUSH = 2'b10, OP_INV = 2'b11;
  localparam logic [1:0] CAUSE_PROT = 2'b01, CAUSE_PRIV = 2'b10;

  logic              wb_busy;
  logic [1:0]        pend_state;
  logic [ADDR_W-1:0] line_q;
  logic [1:0]        next_st;

  wire unused_inputs = &{1'b0, cache_disabled, cache_locked, cmd_attr, cmd_addr[OFF_W-1:0]};

  wire accept     = cmd_valid && !wb_busy && (cmd_op != OP_NONE);
  wire is_inv     = (cmd_op == OP_INV);
  wire priv_fault = is_inv && user_mode;
  wire prot_ok    = is_inv ? prot_store_ok : prot_load_ok;
  wire fault      = priv_fault || !prot_ok;
  wire live       = cmd_hit && (cmd_state != ST_I);
  wire need_wb    = !is_inv && live && (cmd_state == ST_M);
  wire change     = live && !need_wb && (next_st != cmd_state);
  wire [ADDR_W-1:0] line_addr = {cmd_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};

  always_comb begin
    case (cmd_op)
      OP_CLEAN: next_st = (cmd_state == ST_M) ? ST_E : cmd_state;
      OP_FLUSH: next_st = ST_I;
      OP_INV:   next_st = ST_I;
      default:  next_st = cmd_state;
    endcase
  end

  assign busy    = wb_busy;
  assign wb_req  = wb_busy;
  assign wb_addr = line_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wb_busy     <= 1'b0;
      pend_state  <= ST_I;
      line_q      <= '0;
      upd_valid   <= 1'b0;
      upd_state   <= ST_I;
      upd_addr    <= '0;
      bcast_valid <= 1'b0;
      bcast_op    <= OP_NONE;
      bcast_addr  <= '0;
      exc_valid   <= 1'b0;
      exc_cause   <= 2'b00;
      exc_addr    <= '0;
    end else begin
      upd_valid   <= 1'b0;
      bcast_valid <= 1'b0;
      exc_valid   <= 1'b0;
      if (wb_busy) begin
        if (wb_ack) begin
          wb_busy   <= 1'b0;
          upd_valid <= 1'b1;
          upd_state <= pend_state;
          upd_addr  <= line_q;
        end
      end else if (accept) begin
        if (fault) begin
          exc_valid <= 1'b1;
          exc_cause <= priv_fault ? CAUSE_PRIV : CAUSE_PROT;
          exc_addr  <= line_addr;
        end else begin
          if (bcast_enable) begin
            bcast_valid <= 1'b1;
            bcast_op    <= cmd_op;
            bcast_addr  <= line_addr;
          end
          if (need_wb) begin
            wb_busy    <= 1'b1;
            line_q     <= line_addr;
            pend_state <= next_st;
          end else if (change) begin
            upd_valid <= 1'b1;
            upd_state <= next_st;
            upd_addr  <= line_addr;
          end
        end
      end
    end
  end

  assert_wb_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    wb_req && !wb_ack |=> wb_req);
  assert_ack_updates_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wb_req && wb_ack |=> upd_valid && !busy);
  assert_inv_no_wb_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wb_req) |-> ($past(cmd_op) != OP_INV) && ($past(cmd_state) == ST_M));
  assert_fault_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid |-> !upd_valid && !bcast_valid && !wb_req);
  assert_priv_only_inv_R8: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid && (exc_cause == CAUSE_PRIV) |-> ($past(cmd_op) == OP_INV) && $past(user_mode));
  assert_bcast_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
    bcast_valid |-> $past(bcast_enable));
  assert_direct_upd_inval_R5: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid && !$past(wb_req) |-> upd_state == ST_I);
endmodule

// File: tb/cache_maint_ctrl_test.sv
module cache_maint_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 0, cmd_hit = 0, cache_disabled = 0, cache_locked = 0;
  logic prot_load_ok = 1, prot_store_ok = 1, user_mode = 0, bcast_enable = 0, wb_ack = 0;
  logic [1:0] cmd_op = 0, cmd_state = 0;
  logic [3:0] cmd_attr = 0;
  logic [AW-1:0] cmd_addr = 0;
  logic busy, wb_req, upd_valid, bcast_valid, exc_valid;
  logic [1:0] upd_state, bcast_op, exc_cause;
  logic [AW-1:0] wb_addr, upd_addr, bcast_addr, exc_addr;
  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cache_maint_ctrl #(.ADDR_W(AW), .LINE_BYTES(32)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
    .cmd_hit(cmd_hit), .cmd_state(cmd_state), .cmd_attr(cmd_attr),
    .cache_disabled(cache_disabled), .cache_locked(cache_locked),
    .prot_load_ok(prot_load_ok), .prot_store_ok(prot_store_ok), .user_mode(user_mode),
    .bcast_enable(bcast_enable), .busy(busy), .wb_req(wb_req), .wb_addr(wb_addr),
    .wb_ack(wb_ack), .upd_valid(upd_valid), .upd_state(upd_state), .upd_addr(upd_addr),
    .bcast_valid(bcast_valid), .bcast_op(bcast_op), .bcast_addr(bcast_addr),
    .exc_valid(exc_valid), .exc_cause(exc_cause), .exc_addr(exc_addr));

  // fields: op[18:17] hit[16] st[15:14] user[13] ldok[12] stok[11] bce[10] dis[9] lock[8]
  //         | exc[7] cause[6:5] upd[4] ust[3:2] wb[1] bc[0]
  // rows 0,15: R2; 1,2: R3; 3,14: R4; 4: R5; 7,8,11: R6; 5,6,16,17,18: R7;
  // 9,19,20: R8; 10,12,13: R9; 2,6,8,14: R10; 14 and attr sweep: R11
  localparam int NV = 21;
  localparam logic [18:0] VEC [NV] = '{
    19'b01_1_11_0_1_1_0_0_0__0_00_1_10_1_0,
    19'b01_1_10_0_1_1_0_0_0__0_00_0_00_0_0,
    19'b01_1_01_0_1_1_1_0_0__0_00_0_00_0_1,
    19'b10_1_11_0_1_1_0_0_0__0_00_1_00_1_0,
    19'b10_1_10_0_1_1_0_0_0__0_00_1_00_0_0,
    19'b10_0_10_0_1_1_0_0_0__0_00_0_00_0_0,
    19'b01_0_11_0_1_1_1_0_0__0_00_0_00_0_1,
    19'b11_1_11_0_1_1_0_0_0__0_00_1_00_0_0,
    19'b11_1_10_0_1_1_1_0_0__0_00_1_00_0_1,
    19'b11_1_11_1_1_1_1_0_0__1_10_0_00_0_0,
    19'b11_1_11_0_1_0_0_0_0__1_01_0_00_0_0,
    19'b11_1_10_0_0_1_0_0_0__0_00_1_00_0_0,
    19'b01_1_11_0_0_1_1_0_0__1_01_0_00_0_0,
    19'b10_1_10_0_0_1_0_0_0__1_01_0_00_0_0,
    19'b10_1_11_0_1_1_1_1_1__0_00_1_00_1_1,
    19'b01_1_11_1_1_1_0_0_0__0_00_1_10_1_0,
    19'b11_0_11_0_1_1_0_0_0__0_00_0_00_0_0,
    19'b00_1_11_0_1_1_1_0_0__0_00_0_00_0_0,
    19'b11_1_00_0_1_1_0_0_0__0_00_0_00_0_0,
    19'b11_0_00_1_1_1_0_0_0__1_10_0_00_0_0,
    19'b11_1_11_1_1_0_1_0_0__1_10_0_00_0_0
  };

  task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic quiet(input string tag);
    chk({tag, " upd_valid"}, upd_valid, 0);
    chk({tag, " bcast_valid"}, bcast_valid, 0);
    chk({tag, " exc_valid"}, exc_valid, 0);
  endtask

  initial begin
    repeat (1000 * CLK_PERIOD) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R13 busy in reset", busy, 0);
    chk("R13 wb_req in reset", wb_req, 0);
    quiet("R13 reset");
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      logic [18:0] v;
      logic [AW-1:0] a, al;
      v  = VEC[i];
      a  = 32'h1000_0000 + i * 32'h44 + 3;
      al = a & ~32'h1F;
      cmd_op = v[18:17]; cmd_hit = v[16]; cmd_state = v[15:14]; user_mode = v[13];
      prot_load_ok = v[12]; prot_store_ok = v[11]; bcast_enable = v[10];
      cache_disabled = v[9]; cache_locked = v[8]; cmd_attr = 4'(i * 5);
      cmd_addr = a; cmd_valid = 1'b1;
      @(posedge clk); @(negedge clk);
      cmd_valid = 1'b0;
      chk($sformatf("R9 row%0d exc_valid", i), exc_valid, v[7]);
      if (v[7]) begin
        chk($sformatf("R8 row%0d exc_cause", i), exc_cause, v[6:5]);
        chk($sformatf("R14 row%0d exc_addr", i), exc_addr, al);
      end
      chk($sformatf("R10 row%0d bcast_valid", i), bcast_valid, v[0]);
      if (v[0]) begin
        chk($sformatf("R10 row%0d bcast_op", i), bcast_op, v[18:17]);
        chk($sformatf("R14 row%0d bcast_addr", i), bcast_addr, al);
      end
      chk($sformatf("R12 row%0d wb_req", i), wb_req, v[1]);
      chk($sformatf("R12 row%0d busy", i), busy, v[1]);
      if (v[1]) begin
        chk($sformatf("R14 row%0d wb_addr", i), wb_addr, al);
        chk($sformatf("R2 row%0d no early upd", i), upd_valid, 0);
        cmd_op = 2'b11; cmd_hit = 1; cmd_state = 2'b11; user_mode = 0;
        prot_store_ok = 1; bcast_enable = 1; cmd_valid = 1'b1;
        @(posedge clk); @(negedge clk);
        cmd_valid = 1'b0;
        quiet($sformatf("R12 row%0d ignored while busy", i));
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk($sformatf("R12 row%0d wb_req held", i), wb_req, 1);
        wb_ack = 1'b1;
        @(posedge clk); @(negedge clk);
        wb_ack = 1'b0;
        chk($sformatf("R2 row%0d upd after ack", i), upd_valid, v[4]);
        chk($sformatf("R4 row%0d upd_state", i), upd_state, v[3:2]);
        chk($sformatf("R14 row%0d upd_addr", i), upd_addr, al);
        chk($sformatf("R12 row%0d busy cleared", i), busy, 0);
        chk($sformatf("R12 row%0d wb_req cleared", i), wb_req, 0);
        @(posedge clk); @(negedge clk);
        quiet($sformatf("R12 row%0d nothing leaked", i));
      end else begin
        chk($sformatf("R5 row%0d upd_valid", i), upd_valid, v[4]);
        if (v[4]) begin
          chk($sformatf("R6 row%0d upd_state", i), upd_state, v[3:2]);
          chk($sformatf("R14 row%0d upd_addr", i), upd_addr, al);
        end
        @(posedge clk); @(negedge clk);
        chk($sformatf("R1 row%0d pulse ends", i), upd_valid | bcast_valid | exc_valid, 0);
      end
    end

    // R13: reset in the middle of a writeback drops it
    cmd_op = 2'b10; cmd_hit = 1; cmd_state = 2'b11; user_mode = 0;
    prot_load_ok = 1; bcast_enable = 0; cmd_addr = 32'hABCD_0040; cmd_valid = 1'b1;
    @(posedge clk); @(negedge clk);
    cmd_valid = 1'b0;
    chk("R13 setup wb_req", wb_req, 1);
    rst_n = 1'b0;
    @(posedge clk); @(negedge clk);
    chk("R13 wb dropped", wb_req, 0);
    chk("R13 busy dropped", busy, 0);
    rst_n = 1'b1;
    wb_ack = 1'b1;
    @(posedge clk); @(negedge clk);
    wb_ack = 1'b0;
    chk("R13 stray ack no upd", upd_valid, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule